// File: doc/BRIEF.md
# Ten-Function Integer ALU

A purely combinational arithmetic and logic unit for a single-cycle integer core. It takes two operands of a configurable width, which defaults to 32 bits, and a 4-bit operation code. In the same cycle it returns a result word and a flag that is set when that result is zero. One unit serves two jobs: register and immediate arithmetic, and the address and comparison work behind loads, stores and branches.

The unit supports ten operations: addition, subtraction, AND, OR, XOR, a left shift, logical and arithmetic right shifts, and signed and unsigned set-if-less-than. It produces no carry or overflow flags. Branch logic decides from the zero flag, or from the set-if-less-than result. Codes that the unit does not use give a zero result.

Top module: `tenop_alu`

## Requirements
- R1: Code 0 (ADD) gives a + b modulo 2^W. For example, 0x12341234 + 0x43214321 = 0x55555555, and 0xFFFFFFFF + 1 = 0.
- R2: Code 1 (SUB) gives a - b modulo 2^W. Equal operands give zero.
- R3: Code 2 gives the bitwise AND of a and b, code 3 the bitwise OR and code 4 the bitwise XOR.
- R4: Code 5 (SLL) shifts a left and fills with zeros. The shift amount is the low log2(W) bits of b, which is b[4:0] when W is 32. All higher bits of b are ignored.
- R5: Code 6 (SRL) shifts a right by b[4:0] and fills the vacated upper bits with zeros.
- R6: Code 7 (SRA) shifts a right by b[4:0] and fills the vacated upper bits with copies of a[W-1].
- R7: Code 8 (SLT) gives 1 in bit 0 and zeros elsewhere when a < b as two's-complement signed values. Otherwise it gives all zeros.
- R8: Code 9 (SLTU) gives 1 in bit 0 and zeros elsewhere when a < b as unsigned values. Otherwise it gives all zeros.
- R9: Codes 10 to 15 give a result of zero, whatever the operands are.
- R10: The zero flag is 1 exactly when every bit of the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand; the value that is shifted |
| b_i | input | W | Second operand; its low bits give the shift amount |
| op_i | input | 4 | Operation code, 0 to 9 |
| result_o | output | W | Result of the selected operation |
| zero_o | output | 1 | 1 when result_o is all zeros |

## Verification
The assertions are evaluated every time the inputs change. They check these properties:
- Subtraction of equal operands yields zero, and an addition can be undone by subtracting b again.
- A right shift with a nonzero amount fills the top bit with the sign bit for the arithmetic shift and with zero for the logical shift.
- The comparator never reports less-than for equal operands, and a signed compare of operands with different sign bits follows the sign of a.
- The set-if-less-than results leave their upper bits clear, and unused codes raise the zero flag.

The exact arithmetic values can only be shown by the bench's scenarios. These include the full shift distances with high bits of b set, wrap-around at the word boundary, and signed against unsigned ordering at the sign boundary.

// File: rtl/tenop_alu_pkg.sv
package tenop_alu_pkg;

    // Operation encoding; the numeric values are architectural.
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SLL  = 4'd5,
        OP_SRL  = 4'd6,
        OP_SRA  = 4'd7,
        OP_SLT  = 4'd8,
        OP_SLTU = 4'd9
    } alu_op_e;

    localparam int unsigned OP_W = 4;

    // Codes that produce a one-bit comparison result.
    function automatic logic is_set_cmp(input logic [OP_W-1:0] op);
        return (op == OP_SLT) || (op == OP_SLTU);
    endfunction

    // Codes above the last defined operation.
    function automatic logic is_unused_code(input logic [OP_W-1:0] op);
        return op > OP_SLTU;
    endfunction

endpackage

// File: rtl/tenop_alu_addsub.sv
module tenop_alu_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] b_eff;

    // Two's-complement subtraction: invert b and add the carry-in.
    assign b_eff = sub_i ? ~b_i : b_i;
    assign sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};

    always_comb begin
        if (sub_i && (a_i == b_i))
            AST_SUB_SELF_ZERO: assert (sum_o == '0); // R2
        if (!sub_i)
            AST_ADD_UNDO: assert ((sum_o - b_i) == a_i); // R1
    end
endmodule

// File: rtl/tenop_alu_shift.sv
module tenop_alu_shift #(
    parameter int unsigned W   = 32,
    parameter int unsigned SHW = $clog2(W)
) (
    input  logic [W-1:0]   a_i,
    input  logic [SHW-1:0] amt_i,
    input  logic           left_i,
    input  logic           arith_i,
    output logic [W-1:0]   res_o
);
    logic         fill;
    logic [W-1:0] lft [SHW+1];
    logic [W-1:0] rgt [SHW+1];

    assign fill   = arith_i & a_i[W-1];
    assign lft[0] = a_i;
    assign rgt[0] = a_i;

    // Logarithmic shifter: stage i moves by 2**i when amount bit i is set.
    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int unsigned SH = 1 << i;
        assign lft[i+1] = amt_i[i] ? {lft[i][W-1-SH:0], {SH{1'b0}}} : lft[i];
        assign rgt[i+1] = amt_i[i] ? {{SH{fill}}, rgt[i][W-1:SH]} : rgt[i];
    end

    assign res_o = left_i ? lft[SHW] : rgt[SHW];

    always_comb begin
        if (!left_i && arith_i && (amt_i != '0))
            AST_SRA_SIGN_FILL: assert (res_o[W-1] == a_i[W-1]); // R6
        if (!left_i && !arith_i && (amt_i != '0))
            AST_SRL_ZERO_FILL: assert (res_o[W-1] == 1'b0); // R5
        if (left_i && (amt_i != '0))
            AST_SLL_LSB_CLEAR: assert (res_o[0] == 1'b0); // R4
    end
endmodule

// File: rtl/tenop_alu_compare.sv
module tenop_alu_compare #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         signed_i,
    output logic         lt_o
);
    logic lt_u;
    logic sign_diff;

    assign lt_u      = a_i < b_i;
    assign sign_diff = a_i[W-1] ^ b_i[W-1];
    // With differing signs the negative operand is the smaller one.
    assign lt_o      = (signed_i && sign_diff) ? a_i[W-1] : lt_u;

    always_comb begin
        if (a_i == b_i)
            AST_EQUAL_NOT_LESS: assert (!lt_o); // R8
        if (signed_i && sign_diff)
            AST_SIGNED_BY_SIGN: assert (lt_o == a_i[W-1]); // R7
    end
endmodule

// File: rtl/tenop_alu.sv
module tenop_alu
    import tenop_alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic [OP_W-1:0]   op_i,
    output logic [W-1:0]      result_o,
    output logic              zero_o
);
    localparam int unsigned SHW = $clog2(W);

    logic [W-1:0] sum;
    logic [W-1:0] shifted;
    logic         lt;

    tenop_alu_addsub #(.W(W)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (op_i == OP_SUB),
        .sum_o (sum)
    );

    tenop_alu_shift #(.W(W), .SHW(SHW)) u_shift (
        .a_i     (a_i),
        .amt_i   (b_i[SHW-1:0]),
        .left_i  (op_i == OP_SLL),
        .arith_i (op_i == OP_SRA),
        .res_o   (shifted)
    );

    tenop_alu_compare #(.W(W)) u_compare (
        .a_i      (a_i),
        .b_i      (b_i),
        .signed_i (op_i == OP_SLT),
        .lt_o     (lt)
    );

    always_comb begin
        unique case (op_i)
            OP_ADD, OP_SUB:          result_o = sum;
            OP_AND:                  result_o = a_i & b_i;
            OP_OR:                   result_o = a_i | b_i;
            OP_XOR:                  result_o = a_i ^ b_i;
            OP_SLL, OP_SRL, OP_SRA:  result_o = shifted;
            OP_SLT, OP_SLTU:         result_o = {{(W-1){1'b0}}, lt};
            default:                 result_o = '0;
        endcase
    end

    assign zero_o = ~|result_o;

    always_comb begin
        if (is_set_cmp(op_i))
            AST_SET_UPPER_CLEAR: assert (result_o[W-1:1] == '0); // R7
        if (is_unused_code(op_i))
            AST_UNUSED_ZERO: assert (zero_o); // R9
        if (is_set_cmp(op_i))
            AST_SET_FLAG_MATCH: assert (zero_o == !lt); // R10
    end
endmodule

// File: tb/tenop_alu_tb.sv
module tenop_alu_tb;
    localparam int W = 32;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [3:0]   op;
        string        req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic [3:0]   op_i = 4'd0;
    logic [W-1:0] result_o;
    logic         zero_o;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    drv_done = 1'b0;
    bit    ended = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    tenop_alu #(.W(W)) u_dut (
        .a_i(a_i), .b_i(b_i), .op_i(op_i),
        .result_o(result_o), .zero_o(zero_o)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] a,
                                           input logic [W-1:0] b,
                                           input logic [3:0] op);
        case (op)
            4'd0: return a + b;
            4'd1: return a - b;
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return a ^ b;
            4'd5: return a << b[4:0];
            4'd6: return a >> b[4:0];
            4'd7: return W'($signed(a) >>> b[4:0]);
            4'd8: return {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            4'd9: return {{(W-1){1'b0}}, (a < b)};
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd5: return "R4";
            4'd6: return "R5";
            4'd7: return "R6";
            4'd8: return "R7";
            4'd9: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic push(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [3:0] op, input string req);
        item_t it;
        @(posedge clk);
        a_i  <= a;
        b_i  <= b;
        op_i <= op;
        it.a = a; it.b = b; it.op = op; it.req = req;
        q.push_back(it);
    endtask

    // Monitor: compares at the falling edge, half a cycle after the drive.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && q.size() > 0) begin
                item_t it;
                logic [W-1:0] exp;
                it  = q.pop_front();
                exp = model(it.a, it.b, it.op);
                checks++;
                if (result_o !== exp) begin
                    fails++;
                    $display("FAIL %s result op=%0d a=%h b=%h actual=%h expected=%h",
                             it.req, it.op, it.a, it.b, result_o, exp);
                end
                checks++;
                if (zero_o !== (exp == '0)) begin
                    fails++;
                    $display("FAIL R10 zero flag (%s op=%0d) actual=%b expected=%b",
                             it.req, it.op, zero_o, (exp == '0));
                end
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        rst <= 1'b0;
        // Idle state: all-zero inputs give zero result and set flag (R1, R10)
        push(32'h0, 32'h0, 4'd0, "R1");
        // R1 add, including the word-boundary wrap
        push(32'h12341234, 32'h43214321, 4'd0, "R1");
        push(32'hFFFFFFFF, 32'h1, 4'd0, "R1");
        // R2 subtract
        push(32'h5, 32'h7, 4'd1, "R2");
        push(32'hDEADBEEF, 32'hDEADBEEF, 4'd1, "R2");
        // R3 logic
        push(32'hF0F0_1234, 32'h0FF0_FFFF, 4'd2, "R3");
        push(32'hF0F0_1234, 32'h0FF0_0000, 4'd3, "R3");
        push(32'hA5A5_A5A5, 32'hA5A5_A5A5, 4'd4, "R3");
        // R4 left shift; upper bits of b ignored
        push(32'h8000_0001, 32'h1F, 4'd5, "R4");
        push(32'h0000_0003, 32'hFFFF_FFE4, 4'd5, "R4");
        push(32'h1234_5678, 32'h20, 4'd5, "R4");
        // R5 logical right shift
        push(32'h8000_0000, 32'h1F, 4'd6, "R5");
        push(32'hF000_000F, 32'h4, 4'd6, "R5");
        // R6 arithmetic right shift
        push(32'h8000_0000, 32'h1F, 4'd7, "R6");
        push(32'h7000_0000, 32'h41C, 4'd7, "R6");
        push(32'hF000_000F, 32'h0, 4'd7, "R6");
        // R7 signed compare at the sign boundary
        push(32'hFFFF_FFFF, 32'h1, 4'd8, "R7");
        push(32'h1, 32'hFFFF_FFFF, 4'd8, "R7");
        push(32'h8000_0000, 32'h7FFF_FFFF, 4'd8, "R7");
        push(32'h3, 32'h3, 4'd8, "R7");
        // R8 unsigned compare on the same patterns
        push(32'hFFFF_FFFF, 32'h1, 4'd9, "R8");
        push(32'h1, 32'hFFFF_FFFF, 4'd9, "R8");
        push(32'h3, 32'h3, 4'd9, "R8");
        // R9 unused codes
        for (int c = 10; c < 16; c++)
            push(32'hFFFF_FFFF, 32'h1234_5678, 4'(c), "R9");
        // Mixed patterns over every code
        lfsr = 32'hACE1_2468;
        for (int k = 0; k < 160; k++) begin
            logic [31:0] ra;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ra   = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            push(ra, lfsr, 4'(k % 16), req_of(4'(k % 16)));
        end
        drv_done = 1'b1;
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        finish_run();
    end
endmodule